// File: doc/BRIEF.md
# Per-Channel Sample Reducer

This datapath unit sits behind a multi-channel converter and turns short runs of conversion results into one value per run. Every incoming sample carries a channel tag. A packed control word sets two things for each channel: how many consecutive samples form one set (1, 2, 4 or 8), and what to do with that set. The unit can forward the sample unchanged, take the truncated arithmetic mean, or take the median.

Samples for one channel are gathered until the set is full. The result then leaves on the clock edge that takes the last sample, together with its channel tag and a one-cycle valid strobe. A busy flag stays high while a set is partly gathered. If a sample for another channel arrives before the set is full, the partial set is dropped and the new sample starts its own set. The median comes from a sorting network over the whole set. The mean comes from a running sum shifted right.

Top module: `sample_reducer`

## Requirements
- R1: For channel n, the set-size code sits in `ctrlWord[2n+1:2n]` and the reduction code sits in `ctrlWord[2n+17:2n+16]`. The unit reads these fields when a set begins.
- R2: A sample is forwarded unchanged, with `outValid` high on the edge that takes it, when its channel's reduction code is 0 (none) or 3 (reserved), or when its set-size code is 0.
- R3: With reduction code 1 (mean), the result is the sum of the set's samples shifted right by the set-size code, which truncates toward zero.
- R4: With reduction code 2 (median), the result is the lower of the two middle values of the sorted set.
- R5: Set-size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 samples. `outValid` stays low until the last sample of a set is taken, and rises on that edge.
- R6: `avgBusy` is high from the edge after the first sample of a set of two or more until the edge that takes the set's last sample.
- R7: A sample tagged with a channel other than the one being gathered drops the partial set, which then never produces an output. That sample starts a new set under its own channel's codes.
- R8: `outChan` carries the channel tag of the result on `outValid`.
- R9: After reset, `outValid`, `avgBusy` and `outData` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 16+2*NUM_CH | Packed set-size and reduction codes for each channel |
| inValid | input | 1 | Input sample qualifier |
| inChan | input | $clog2(NUM_CH) | Channel tag of the input sample |
| inData | input | RES_BITS | Input conversion result |
| outValid | output | 1 | One-cycle strobe for a finished result |
| outChan | output | $clog2(NUM_CH) | Channel tag of the result |
| outData | output | RES_BITS | Reduced result |
| avgBusy | output | 1 | High while a set is partly gathered |

## Verification
A wrong slot index or a stale sort entry shows up as a wrong median or mean value in the same cycle that the set completes. A wrong set counter shows up either as an `outValid` pulse one or more samples early or late, or as `avgBusy` not matching the expected gather state at the very next sample. A failure to drop a partial set after a channel switch shows up as an unexpected result, or as a polluted value, when the new set finishes. A reference model in the bench follows the same sample stream. Long random runs with mixed channels bring out each of these faults within a few sets.

// File: rtl/sample_reducer_pkg.sv
package sample_reducer_pkg;
  localparam int SET_MAX = 8;
  localparam int SLOT_W = $clog2(SET_MAX);

  typedef enum logic [1:0] {
    RED_NONE   = 2'd0,
    RED_MEAN   = 2'd1,
    RED_MEDIAN = 2'd2,
    RED_RSVD   = 2'd3
  } redMode_e;

  typedef struct packed {
    logic              bypass;
    logic              start;
    logic              add;
    logic              last;
    logic              useMedian;
    logic [1:0]        shift;
    logic [SLOT_W-1:0] slot;
  } redStrobe_t;
endpackage

// File: rtl/sample_reducer_ctrl.sv
module sample_reducer_ctrl
  import sample_reducer_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int CTRL_W = 16 + 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  output redStrobe_t        strobe,
  output logic              avgBusy
);
  logic              active;
  logic [CH_W-1:0]   curChan;
  logic [SLOT_W-1:0] idx;
  logic [1:0]        shiftQ;
  logic              medQ;
  logic [1:0]        cfgCnt;
  redMode_e          cfgMode;
  logic              cfgBypass;
  logic              sameSet;
  logic [SLOT_W-1:0] lastIdx;

  always_comb begin
    cfgCnt    = ctrlWord[2*int'(inChan) +: 2];
    cfgMode   = redMode_e'(ctrlWord[16 + 2*int'(inChan) +: 2]);
    cfgBypass = (cfgCnt == 2'd0) || !(cfgMode == RED_MEAN || cfgMode == RED_MEDIAN);
    sameSet   = active && (inChan == curChan);
    lastIdx   = SLOT_W'((4'd1 << shiftQ) - 4'd1);
    strobe    = '0;
    if (inValid) begin
      if (sameSet) begin
        strobe.add       = 1'b1;
        strobe.slot      = idx;
        strobe.shift     = shiftQ;
        strobe.useMedian = medQ;
        strobe.last      = (idx == lastIdx);
      end else if (cfgBypass) begin
        strobe.bypass = 1'b1;
      end else begin
        strobe.start     = 1'b1;
        strobe.shift     = cfgCnt;
        strobe.useMedian = (cfgMode == RED_MEDIAN);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curChan <= '0;
      idx     <= '0;
      shiftQ  <= '0;
      medQ    <= 1'b0;
    end else if (strobe.start) begin
      active  <= 1'b1;
      curChan <= inChan;
      idx     <= SLOT_W'(1);
      shiftQ  <= cfgCnt;
      medQ    <= (cfgMode == RED_MEDIAN);
    end else if (strobe.add) begin
      if (strobe.last) active <= 1'b0;
      else idx <= idx + SLOT_W'(1);
    end else if (strobe.bypass) begin
      active <= 1'b0;
    end
  end

  assign avgBusy = active;

  AST_IDX_IN_SET: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (idx != '0) && (idx <= lastIdx) && (shiftQ != 2'd0)); // R5
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !avgBusy); // R6
  AST_SWITCH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (active && inValid && inChan != curChan && !cfgBypass)
      |=> (active && idx == SLOT_W'(1) && curChan == $past(inChan))); // R7
endmodule

// File: rtl/sample_reducer_datapath.sv
module sample_reducer_datapath
  import sample_reducer_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int SUM_W = RES_BITS + SLOT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  redStrobe_t          strobe,
  input  logic [RES_BITS-1:0] inData,
  input  logic [CH_W-1:0]     inChan,
  output logic                outValid,
  output logic [CH_W-1:0]     outChan,
  output logic [RES_BITS-1:0] outData
);
  logic [RES_BITS-1:0] bufQ    [SET_MAX];
  logic [RES_BITS-1:0] nextBuf [SET_MAX];
  logic [RES_BITS-1:0] work    [SET_MAX];
  logic [RES_BITS-1:0] tmp;
  logic [SUM_W-1:0]    sumQ;
  logic [SUM_W-1:0]    sumNext;
  logic [RES_BITS-1:0] meanVal;
  logic [SLOT_W-1:0]   medIdx;
  logic [SLOT_W-1:0]   topIdx;

  for (genvar i = 0; i < SET_MAX; i++) begin : g_slot
    always_comb begin
      if (strobe.start) nextBuf[i] = (i == 0) ? inData : '1;
      else if (strobe.add && strobe.slot == SLOT_W'(i)) nextBuf[i] = inData;
      else nextBuf[i] = bufQ[i];
    end
    always_ff @(posedge clk) begin
      if (!rstN) bufQ[i] <= '0;
      else if (strobe.start || strobe.add) bufQ[i] <= nextBuf[i];
    end
  end

  always_comb begin
    tmp = '0;
    for (int k = 0; k < SET_MAX; k++) work[k] = nextBuf[k];
    for (int s = 0; s < SET_MAX; s++) begin
      for (int j = s % 2; j + 1 < SET_MAX; j += 2) begin
        if (work[j] > work[j+1]) begin
          tmp       = work[j];
          work[j]   = work[j+1];
          work[j+1] = tmp;
        end
      end
    end
  end

  always_comb begin
    sumNext = (strobe.start ? '0 : sumQ) + SUM_W'(inData);
    meanVal = RES_BITS'(sumNext >> strobe.shift);
    topIdx  = SLOT_W'((4'd1 << strobe.shift) - 4'd1);
    medIdx  = topIdx >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ     <= '0;
      outValid <= 1'b0;
      outChan  <= '0;
      outData  <= '0;
    end else begin
      if (strobe.start || strobe.add) sumQ <= sumNext;
      outValid <= strobe.bypass || strobe.last;
      if (strobe.bypass) begin
        outData <= inData;
        outChan <= inChan;
      end else if (strobe.last) begin
        outData <= strobe.useMedian ? work[medIdx] : meanVal;
        outChan <= inChan;
      end
    end
  end

  AST_MEAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.last && !strobe.useMedian) |-> (meanVal >= work[0] && meanVal <= work[topIdx])); // R3
  for (genvar k = 0; k + 1 < SET_MAX; k++) begin : g_ord
    AST_SORT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
      strobe.last |-> work[k] <= work[k+1]); // R4
  end
endmodule

// File: rtl/sample_reducer.sv
module sample_reducer
  import sample_reducer_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int CTRL_W = 16 + 2 * NUM_CH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic                inValid,
  input  logic [CH_W-1:0]     inChan,
  input  logic [RES_BITS-1:0] inData,
  output logic                outValid,
  output logic [CH_W-1:0]     outChan,
  output logic [RES_BITS-1:0] outData,
  output logic                avgBusy
);
  redStrobe_t strobe;

  sample_reducer_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .inValid(inValid),
    .inChan(inChan), .strobe(strobe), .avgBusy(avgBusy)
  );

  sample_reducer_datapath #(.RES_BITS(RES_BITS), .NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inChan(inChan),
    .outValid(outValid), .outChan(outChan), .outData(outData)
  );

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R2
  AST_NO_BUSY_AFTER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inValid && avgBusy && inChan != outChan)) |-> !avgBusy); // R6
endmodule

// File: tb/sample_reducer_tb_top.sv
module sample_reducer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 10;
  localparam int NCH = 8;
  localparam int FULL = (1 << RES) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic inValid = 1'b0;
  logic [2:0] inChan = '0;
  logic [RES-1:0] inData = '0;
  logic outValid;
  logic [2:0] outChan;
  logic [RES-1:0] outData;
  logic avgBusy;

  int checks = 0;
  int errors = 0;
  int qCh[$];
  int qVal[$];
  string qTag[$];
  int benchMode[NCH];
  int benchCnt[NCH];
  bit mActive = 0;
  int mCh = 0, mNeed = 0, mN = 0;
  bit mMed = 0;
  int mVals[8];
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  sample_reducer #(.RES_BITS(RES), .NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .inValid(inValid), .inChan(inChan),
    .inData(inData), .outValid(outValid), .outChan(outChan), .outData(outData),
    .avgBusy(avgBusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  // R1: build the packed word from per-channel codes
  task automatic applyCfg();
    for (int i = 0; i < NCH; i++) begin
      ctrlWord[2*i +: 2]      = 2'(benchCnt[i]);
      ctrlWord[16 + 2*i +: 2] = 2'(benchMode[i]);
    end
  endtask

  task automatic pushExp(int ch, int val, string tag);
    qCh.push_back(ch);
    qVal.push_back(val);
    qTag.push_back(tag);
  endtask

  function automatic int reduceSet();
    int s[8];
    int t, sum;
    sum = 0;
    for (int i = 0; i < mNeed; i++) begin s[i] = mVals[i]; sum += mVals[i]; end
    for (int i = 0; i < mNeed; i++)
      for (int j = 0; j + 1 < mNeed - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    if (mMed) return s[(mNeed - 1) / 2];
    return sum / mNeed;
  endfunction

  task automatic modelStep(int ch, int val);
    if (mActive && ch == mCh) begin
      mVals[mN] = val;
      mN++;
      if (mN == mNeed) begin
        pushExp(ch, reduceSet(), mMed ? "R4 R5 R1" : "R3 R5 R1");
        mActive = 0;
      end
    end else if (benchCnt[ch] == 0 || !(benchMode[ch] == 1 || benchMode[ch] == 2)) begin
      pushExp(ch, val, "R2 R1");
      mActive = 0;
    end else begin
      mActive = 1; mCh = ch; mNeed = 1 << benchCnt[ch]; mN = 1;
      mVals[0] = val; mMed = (benchMode[ch] == 2);
    end
  endtask

  task automatic feed(int ch, int val);
    @(negedge clk);
    check(avgBusy == mActive, "R6 busy", int'(avgBusy), int'(mActive));
    inValid = 1'b1;
    inChan = 3'(ch);
    inData = RES'(val);
    modelStep(ch, val);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(avgBusy == mActive, "R6 busy idle", int'(avgBusy), int'(mActive));
      inValid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qCh.size() == 0) begin
        check(0, "R5 R7 unexpected output", int'(outData), -1);
      end else begin
        int ec, ev;
        string et;
        ec = qCh.pop_front();
        ev = qVal.pop_front();
        et = qTag.pop_front();
        check(int'(outChan) == ec, "R8 channel tag", int'(outChan), ec);
        check(int'(outData) == ev, et, int'(outData), ev);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    benchMode = '{0, 1, 1, 1, 2, 2, 2, 3};
    benchCnt  = '{3, 0, 1, 3, 2, 3, 1, 2};
    applyCfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 0, "R9 outValid", int'(outValid), 0);
    check(avgBusy == 0, "R9 avgBusy", int'(avgBusy), 0);
    check(outData == 0, "R9 outData", int'(outData), 0);
    rstN = 1'b1;

    // R2: forwarding channels
    feed(0, 17); feed(0, 1000); feed(1, 5); feed(7, 600); feed(7, 3);
    idle(2);
    // R3 mean of two, eight
    feed(2, 10); feed(2, 13); feed(3, 1); feed(3, 2); feed(3, 3); feed(3, 4);
    feed(3, 5); feed(3, 6); feed(3, 7); feed(3, 9);
    idle(1);
    // R4 median of four, eight, two
    feed(4, 900); feed(4, 5); feed(4, 300); feed(4, 100);
    feed(5, 8); feed(5, 1); feed(5, 7); feed(5, 2); feed(5, 6); feed(5, 3); feed(5, 5); feed(5, 4);
    feed(6, 700); feed(6, 20);
    idle(1);
    // R5: set not complete yet -> no output
    feed(3, FULL); feed(3, FULL); feed(3, FULL);
    idle(1);
    check(outValid == 0, "R5 partial set", int'(outValid), 0);
    for (int i = 0; i < 5; i++) feed(3, FULL);
    idle(2);
    // R7: switch mid-set drops partial result
    feed(3, 50); feed(3, 60); feed(3, 70);
    feed(4, 11); feed(4, 44); feed(4, 22); feed(4, 33);
    feed(5, 9); feed(5, 9); feed(0, 123);
    idle(1);
    check(avgBusy == 0, "R7 busy after switch to forwarding", int'(avgBusy), 0);
    // R1: reconfigure channel 2 to forwarding via count code 0
    benchCnt[2] = 0; benchMode[6] = 1; benchCnt[6] = 2;
    applyCfg();
    feed(2, 77); feed(6, 1); feed(6, 2); feed(6, 4); feed(6, 8);
    idle(1);
    // random runs across channels
    for (int r = 0; r < 400; r++) begin
      int ch, len;
      ch = nextRand() % NCH;
      len = 1 + nextRand() % 9;
      for (int k = 0; k < len; k++) feed(ch, nextRand() % (FULL + 1));
      if (nextRand() % 4 == 0) idle(1);
    end
    idle(4);
    check(qCh.size() == 0, "R5 results outstanding", qCh.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule